// File: doc/BRIEF.md
# Banked Group Interrupt Enable Access Gate

This block holds a one-bit enable for a group of interrupts. It keeps two copies of that bit, one for the secure world and one for the non-secure world. The core hands it every read or write of the enable register, together with the current exception level and the control state that governs such accesses. The block works out what the access does. It can be undefined, trap to a higher level, be redirected to a virtual copy held elsewhere, or reach one of the two real copies.

The decision comes from a priority chain of checks that depends on the exception level. The first check that matches sets the outcome, and its result is registered. One cycle after the access strobe the block presents a result code, the level a trap goes to, a syndrome class, the read data and, for a redirected write, a one-cycle strobe with the new virtual enable value. The register is 64 bits wide, but only bit 0 holds state.

Top module: `irq_grp_enable_gate`

## Requirements
- R1: Only bit 0 holds state. Read data bits 63:1 are always zero, and write data bits 63:1 have no effect on any copy.
- R2: After reset both real copies hold 0 (disabled).
- R3: Any access at level 0 gives result code 0 (undefined).
- R4: Result codes are 0 undefined, 1 trap, 2 virtual, 3 real. A trap reports its target level (1, 2 or 3) on `trap_level` and the class 0x18 on `syn_class`. Every other outcome reports 0 on both.
- R5: At level 1 the first matching check wins, in this order:
  1. the debug undefined check (R10);
  2. `sysif_en1`=0 traps to level 1;
  3. the fine-grained trap (R6) traps to level 2;
  4. `trap_all`=1 with level 2 enabled and 64-bit traps to level 2;
  5. `virt_route`=1 with level 2 enabled and 64-bit gives virtual;
  6. level 3 present, 64-bit and `el3_irq_route`=1 traps to level 3 (or see R9);
  7. otherwise the access is real.

  Level 2 counts as enabled when `el2_present`=1 and either level 3 is absent or `ns_sel`=1.
- R6: The fine-grained trap fires when level 2 is enabled and 64-bit, level 3 is absent or `fg_gate`=1, and the trap bit for the direction is set. Reads use `fg_rd_trap` and writes use `fg_wr_trap`.
- R7: At level 2 the chain is:
  1. the debug undefined check;
  2. `sysif_en2`=0 traps to level 2;
  3. the level 3 IRQ trap;
  4. otherwise the access is real.

  The fine-grained, trap-all and virtual checks do not apply.
- R8: At level 3, `sysif_en3`=0 traps to level 3. Otherwise the access is real.
- R9: When the level 3 IRQ trap condition is reached while `halted`=1 and `sec_dbg_off`=1, the result is undefined rather than a trap.
- R10: At level 1 or 2, the access is undefined ahead of every other check when all of the following are 1: `halted`, `el3_present`, `sec_dbg_off`, `dbg_prio_strap`, `el3_wide` and `el3_irq_route`.
- R11: When level 3 is present, `ns_sel`=0 selects the secure copy and `ns_sel`=1 selects the non-secure copy. Without level 3 the secure copy is used. A real read returns the selected copy in bit 0. A real write loads write data bit 0 into the selected copy only.
- R12: Outputs are registered. `res_valid` is high exactly one cycle after `acc_valid`. With no access, all outputs are zero. Read data is zero unless the outcome is a real read.
- R13: A virtual write pulses `virt_we` for one cycle with `virt_wbit` equal to write data bit 0. Neither real copy changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 write, 0 read |
| acc_wdata | input | 64 | Write data |
| cur_level | input | 2 | Current exception level |
| el2_present | input | 1 | Level 2 implemented |
| el2_wide | input | 1 | Level 2 runs 64-bit |
| el3_present | input | 1 | Level 3 implemented |
| el3_wide | input | 1 | Level 3 runs 64-bit |
| sysif_en1 | input | 1 | Register interface enable, level 1 |
| sysif_en2 | input | 1 | Register interface enable, level 2 |
| sysif_en3 | input | 1 | Register interface enable, level 3 |
| fg_rd_trap | input | 1 | Fine-grained read trap |
| fg_wr_trap | input | 1 | Fine-grained write trap |
| fg_gate | input | 1 | Level 3 permission for fine-grained traps |
| trap_all | input | 1 | Trap all level 1 accesses to level 2 |
| virt_route | input | 1 | Redirect level 1 accesses to the virtual copy |
| el3_irq_route | input | 1 | IRQs routed to level 3 |
| ns_sel | input | 1 | Non-secure state |
| halted | input | 1 | Core in debug halt |
| sec_dbg_off | input | 1 | Secure debug disabled |
| dbg_prio_strap | input | 1 | Debug undefined takes top priority |
| res_valid | output | 1 | Result valid |
| res_code | output | 2 | Outcome code |
| trap_level | output | 2 | Trap target level |
| syn_class | output | 6 | Syndrome class |
| rd_data | output | 64 | Read data |
| virt_we | output | 1 | Virtual enable write strobe |
| virt_wbit | output | 1 | Virtual enable write value |

## Verification
The sweep biases the interface enables high, so the deeper parts of each chain get reached. It then crosses halt, secure-debug-disable, the strap and IRQ routing, which shows whether R9 and R10 sit at the right place in the chain. A design that dropped the level-3 gate on the fine-grained trap, used the read trap bit for writes, or ran the virtual check at level 2 would report a trap or a redirect where the model predicts a real access. Write-then-read pairs on both banks, including writes of all ones and of all ones but bit 0, would expose a bank chosen wrongly when level 3 is absent, stored upper bits, or a virtual write that leaked into a real copy.

// File: rtl/irq_grp_enable_gate.sv
module irq_grp_enable_gate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [63:0] acc_wdata,
  input  logic [1:0]  cur_level,
  input  logic        el2_present,
  input  logic        el2_wide,
  input  logic        el3_present,
  input  logic        el3_wide,
  input  logic        sysif_en1,
  input  logic        sysif_en2,
  input  logic        sysif_en3,
  input  logic        fg_rd_trap,
  input  logic        fg_wr_trap,
  input  logic        fg_gate,
  input  logic        trap_all,
  input  logic        virt_route,
  input  logic        el3_irq_route,
  input  logic        ns_sel,
  input  logic        halted,
  input  logic        sec_dbg_off,
  input  logic        dbg_prio_strap,
  output logic        res_valid,
  output logic [1:0]  res_code,
  output logic [1:0]  trap_level,
  output logic [5:0]  syn_class,
  output logic [63:0] rd_data,
  output logic        virt_we,
  output logic        virt_wbit
);
  localparam logic [1:0] RC_UNDEF = 2'd0;
  localparam logic [1:0] RC_TRAP  = 2'd1;
  localparam logic [1:0] RC_VIRT  = 2'd2;
  localparam logic [1:0] RC_REAL  = 2'd3;
  localparam logic [5:0] TRAP_CLASS = 6'h18;

  logic [1:0] bank_q;
  logic [1:0] code_d;
  logic [1:0] lvl_d;

  wire el2_a64     = el2_present & (~el3_present | ns_sel) & el2_wide;
  wire irq_to3     = el3_present & el3_wide & el3_irq_route;
  wire dbg_lock    = halted & sec_dbg_off;
  wire early_undef = dbg_lock & dbg_prio_strap & irq_to3;
  wire fg_bit      = acc_write ? fg_wr_trap : fg_rd_trap;
  wire fg_hit      = el2_a64 & (~el3_present | fg_gate) & fg_bit;
  wire bank_sel    = el3_present & ns_sel;
  wire cur_bit     = bank_q[bank_sel];

  always_comb begin
    code_d = RC_REAL;
    lvl_d  = 2'd0;
    unique case (cur_level)
      2'd0: code_d = RC_UNDEF;
      2'd1: begin
        if (early_undef)                code_d = RC_UNDEF;
        else if (!sysif_en1)            begin code_d = RC_TRAP; lvl_d = 2'd1; end
        else if (fg_hit)                begin code_d = RC_TRAP; lvl_d = 2'd2; end
        else if (el2_a64 && trap_all)   begin code_d = RC_TRAP; lvl_d = 2'd2; end
        else if (el2_a64 && virt_route) code_d = RC_VIRT;
        else if (irq_to3 && dbg_lock)   code_d = RC_UNDEF;
        else if (irq_to3)               begin code_d = RC_TRAP; lvl_d = 2'd3; end
      end
      2'd2: begin
        if (early_undef)                code_d = RC_UNDEF;
        else if (!sysif_en2)            begin code_d = RC_TRAP; lvl_d = 2'd2; end
        else if (irq_to3 && dbg_lock)   code_d = RC_UNDEF;
        else if (irq_to3)               begin code_d = RC_TRAP; lvl_d = 2'd3; end
      end
      default: begin
        if (!sysif_en3)                 begin code_d = RC_TRAP; lvl_d = 2'd3; end
      end
    endcase
  end

  wire real_wr = acc_valid & acc_write & (code_d == RC_REAL);
  wire real_rd = acc_valid & ~acc_write & (code_d == RC_REAL);
  wire virt_wr = acc_valid & acc_write & (code_d == RC_VIRT);
  wire is_trap = acc_valid & (code_d == RC_TRAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q     <= 2'b00;
      res_valid  <= 1'b0;
      res_code   <= RC_UNDEF;
      trap_level <= 2'd0;
      syn_class  <= 6'd0;
      rd_data    <= 64'd0;
      virt_we    <= 1'b0;
      virt_wbit  <= 1'b0;
    end else begin
      if (real_wr) bank_q[bank_sel] <= acc_wdata[0];
      res_valid  <= acc_valid;
      res_code   <= acc_valid ? code_d : RC_UNDEF;
      trap_level <= is_trap ? lvl_d : 2'd0;
      syn_class  <= is_trap ? TRAP_CLASS : 6'd0;
      rd_data    <= {63'd0, real_rd & cur_bit};
      virt_we    <= virt_wr;
      virt_wbit  <= virt_wr & acc_wdata[0];
    end
  end
endmodule

// File: rtl/irq_grp_enable_gate_chk.sv
module irq_grp_enable_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [1:0]  cur_level,
  input logic        res_valid,
  input logic [1:0]  res_code,
  input logic [1:0]  trap_level,
  input logic [5:0]  syn_class,
  input logic [63:0] rd_data,
  input logic        virt_we
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[63:1] == 63'd0);

  a_r3_level0_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cur_level == 2'd0) |=> (res_valid && res_code == 2'd0));

  a_r4_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'd1) |-> (syn_class == 6'h18 && trap_level != 2'd0));

  a_r4_no_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
    (res_code != 2'd1) |-> (syn_class == 6'd0 && trap_level == 2'd0));

  a_r8_level3_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cur_level == 2'd3) |=> (res_code == 2'd1 || res_code == 2'd3));

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!res_valid && !virt_we && rd_data == 64'd0));

  a_r13_virt_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    virt_we |-> (res_valid && res_code == 2'd2));
endmodule

bind irq_grp_enable_gate irq_grp_enable_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .cur_level(cur_level),
  .res_valid(res_valid), .res_code(res_code), .trap_level(trap_level),
  .syn_class(syn_class), .rd_data(rd_data), .virt_we(virt_we)
);

// File: tb/irq_grp_enable_gate_bench.sv
module irq_grp_enable_gate_bench;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [63:0] acc_wdata = 0;
  logic [1:0] cur_level = 0;
  logic el2_present = 0, el2_wide = 0, el3_present = 0, el3_wide = 0;
  logic sysif_en1 = 0, sysif_en2 = 0, sysif_en3 = 0;
  logic fg_rd_trap = 0, fg_wr_trap = 0, fg_gate = 0, trap_all = 0, virt_route = 0;
  logic el3_irq_route = 0, ns_sel = 0, halted = 0, sec_dbg_off = 0, dbg_prio_strap = 0;
  logic res_valid, virt_we, virt_wbit;
  logic [1:0] res_code, trap_level;
  logic [5:0] syn_class;
  logic [63:0] rd_data;

  int checks = 0, fails = 0;
  logic [1:0] model_bank = 2'b00;
  bit done = 0;

  always #2 clk = ~clk;

  irq_grp_enable_gate u_irq_grp_enable_gate (.*);

  task automatic predict(output logic [1:0] code, output logic [1:0] lvl, output string tag);
    logic l2 = el2_present && el2_wide && (!el3_present || ns_sel);
    logic r3 = el3_present && el3_wide && el3_irq_route;
    logic lock = halted && sec_dbg_off;
    logic fg = l2 && (!el3_present || fg_gate) && (acc_write ? fg_wr_trap : fg_rd_trap);
    string rtag = acc_write ? "R13" : "R11";
    code = 2'd3; lvl = 2'd0; tag = acc_write ? "R1" : "R11";
    if (cur_level == 0) begin code = 0; tag = "R3"; return; end
    if (cur_level == 3) begin
      if (!sysif_en3) begin code = 1; lvl = 3; end
      tag = "R8"; return;
    end
    if (lock && dbg_prio_strap && r3) begin code = 0; tag = "R10"; return; end
    if (cur_level == 1) begin
      if (!sysif_en1) begin code = 1; lvl = 1; tag = "R5"; return; end
      if (fg) begin code = 1; lvl = 2; tag = "R6"; return; end
      if (l2 && trap_all) begin code = 1; lvl = 2; tag = "R5"; return; end
      if (l2 && virt_route) begin code = 2; tag = rtag; return; end
    end else if (!sysif_en2) begin code = 1; lvl = 2; tag = "R7"; return; end
    if (r3) begin
      if (lock) begin code = 0; tag = "R9"; end
      else begin code = 1; lvl = 3; tag = (cur_level == 1) ? "R5" : "R7"; end
    end
  endtask

  task automatic step(input string force_tag);
    logic [1:0] c, l;
    string tag;
    logic [76:0] exp, act;
    logic sel = el3_present && ns_sel;
    predict(c, l, tag);
    if (force_tag != "") tag = force_tag;
    if (!acc_valid) begin
      exp = '0; tag = "R12";
    end else begin
      exp = {1'b1, c, (c == 1) ? l : 2'd0, (c == 1) ? 6'h18 : 6'd0,
             {63'd0, (c == 3 && !acc_write) ? model_bank[sel] : 1'b0},
             (c == 2 && acc_write), (c == 2 && acc_write) ? acc_wdata[0] : 1'b0};
      if (c == 3 && acc_write) model_bank[sel] = acc_wdata[0];
    end
    @(negedge clk);
    act = {res_valid, res_code, trap_level, syn_class, rd_data, virt_we, virt_wbit};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (lvl %0d wr %0d)", tag, act, exp, cur_level, acc_write);
    end
  endtask

  task automatic set_cfg(input logic [1:0] lv, input logic wr, input logic [63:0] wd,
                         input logic e3, input logic ns);
    acc_valid = 1; cur_level = lv; acc_write = wr; acc_wdata = wd;
    el2_present = 1; el2_wide = 1; el3_present = e3; el3_wide = 1;
    sysif_en1 = 1; sysif_en2 = 1; sysif_en3 = 1;
    fg_rd_trap = 0; fg_wr_trap = 0; fg_gate = 0; trap_all = 0; virt_route = 0;
    el3_irq_route = 0; ns_sel = ns; halted = 0; sec_dbg_off = 0; dbg_prio_strap = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    rst_n = 1;
    acc_valid = 0;
    step("R12");
    // R2: both copies disabled after reset
    set_cfg(3, 0, 0, 1, 0); step("R2");
    set_cfg(3, 0, 0, 1, 1); step("R2");
    // R1: upper bits ignored on write, zero on read
    set_cfg(3, 1, '1, 1, 0); step("R1");
    set_cfg(3, 0, 0, 1, 0); step("R1");
    set_cfg(3, 0, 0, 1, 1); step("R11");
    set_cfg(3, 1, 64'hFFFF_FFFF_FFFF_FFFE, 1, 0); step("R1");
    set_cfg(3, 0, 0, 1, 0); step("R1");
    // R11: without level 3 the secure copy is used regardless of ns_sel
    set_cfg(2, 1, 64'h1, 0, 1); step("R11");
    set_cfg(3, 0, 0, 1, 0); step("R11");
    set_cfg(3, 0, 0, 1, 1); step("R11");
    // R13: virtual write leaves real copies alone
    set_cfg(1, 1, 64'h0, 1, 1); virt_route = 1; step("R13");
    set_cfg(3, 0, 0, 1, 1); step("R13");
    set_cfg(3, 0, 0, 1, 0); step("R13");
    // R6: fine-grained trap direction
    set_cfg(1, 1, 0, 1, 1); fg_gate = 1; fg_rd_trap = 1; step("R6");
    set_cfg(1, 0, 0, 1, 1); fg_gate = 1; fg_rd_trap = 1; step("R6");
    set_cfg(1, 0, 0, 1, 1); fg_gate = 0; fg_rd_trap = 1; step("R6");
    // R9/R10: debug-state undefined
    set_cfg(2, 0, 0, 1, 1); el3_irq_route = 1; halted = 1; sec_dbg_off = 1; step("R9");
    set_cfg(1, 0, 0, 1, 1); el3_irq_route = 1; halted = 1; sec_dbg_off = 1;
    dbg_prio_strap = 1; sysif_en1 = 0; step("R10");
    // sweep: all requirements through the model
    for (int i = 0; i < 60000; i++) begin
      acc_valid     = ($urandom % 8) != 0;
      cur_level     = 2'($urandom);
      acc_write     = 1'($urandom);
      acc_wdata     = {$urandom, $urandom};
      el2_present   = ($urandom % 4) != 0;
      el2_wide      = ($urandom % 4) != 0;
      el3_present   = 1'($urandom);
      el3_wide      = ($urandom % 4) != 0;
      sysif_en1     = ($urandom % 4) != 0;
      sysif_en2     = ($urandom % 4) != 0;
      sysif_en3     = ($urandom % 4) != 0;
      fg_rd_trap    = ($urandom % 3) == 0;
      fg_wr_trap    = ($urandom % 3) == 0;
      fg_gate       = 1'($urandom);
      trap_all      = ($urandom % 3) == 0;
      virt_route    = ($urandom % 3) == 0;
      el3_irq_route = ($urandom % 3) == 0;
      ns_sel        = 1'($urandom);
      halted        = 1'($urandom);
      sec_dbg_off   = 1'($urandom);
      dbg_prio_strap = 1'($urandom);
      step("");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule